// File: doc/BRIEF.md
# Packet Framer with Leading CRC Word

The framer builds fixed-length packets from one source of 16-bit payload words. A one-cycle start request arms it. It then accepts ten payload words over a valid/ready input. Each word is written into a small holding store, and a running CRC is updated on the same clock edge that accepts the word. When the tenth word has been taken, the framer closes its input and sends twelve words over a valid/ready output. The first is a fixed marker word. The second is the finished CRC. The last ten are the payload words in the order they arrived.

The check word comes before the data it covers, so nothing can leave until the whole payload has been seen. The framer therefore works store-and-forward, one packet at a time. Back-pressure rules:
- Input: a word moves only on a clock edge where both `in_valid` and `in_ready` are high. `in_ready` is high only while the framer is collecting payload.
- Output: a word moves only on an edge where both `out_valid` and `out_ready` are high. While `out_valid` is high and `out_ready` is low, the output word and its markers stay unchanged.

Top module: `pkt_framer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, `in_ready`, `out_valid`, `out_sop` and `out_eop` are all 0.
- R2: When `start` is sampled high with the framer idle, `in_ready` is 1 from the next cycle. It stays 1 until exactly ten input words have been accepted.
- R3: In the cycle after the tenth payload word is accepted, `in_ready` is 0 and `out_valid` is 1. The first output word is 0xA5A5, shown with `out_sop`=1.
- R4: The second output word is a CRC-16 over the ten payload words in arrival order. It uses polynomial 0x1021, starts from 0xFFFF, feeds each word most significant bit first, and applies no final inversion.
- R5: Output words three to twelve are the payload words in the order they were accepted. `out_eop` is 1 on the twelfth word only, and `out_sop` is 1 on the first word only.
- R6: While `out_valid` is 1 and `out_ready` is 0, the next cycle still shows `out_valid`=1 with the same `out_data`, `out_sop` and `out_eop`.
- R7: `in_ready` is 0 whenever `out_valid` is 1. A `start` pulse while collecting or sending has no effect: the CRC is not restarted, and after the twelfth word the framer is idle with `in_ready`=0.
- R8: Words offered on `in_valid` while `in_ready` is 0 are not stored and do not appear in any later packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to begin collecting one packet's payload |
| in_valid | input | 1 | Payload word offered |
| in_data | input | 16 | Payload word |
| in_ready | output | 1 | Framer accepts a payload word this cycle |
| out_valid | output | 1 | Packet word present |
| out_data | output | 16 | Packet word |
| out_sop | output | 1 | Marks the first word of a packet |
| out_eop | output | 1 | Marks the last word of a packet |
| out_ready | input | 1 | Sink accepts the packet word this cycle |

## Verification
The bench sends several payload patterns and checks every output word against a CRC it computes itself:
- All-zero and all-one payloads separate a correct seed from a zero seed, and catch a missing or extra feedback term.
- Ramp and mixed-bit payloads expose word or bit order errors in both the CRC and the replayed data.

Some runs leave gaps in `in_valid` and deassert `out_ready` at intervals. These show that stalls on either side neither drop, repeat nor reorder words. Directed cases offer words while the input is closed, and pulse `start` during collection and during sending. They show that such stimulus changes neither the stored payload nor the CRC.

// File: rtl/pkt_framer_pkg.sv
package pkt_framer_pkg;
  localparam int unsigned WORD_BITS = 16;
  localparam int unsigned BODY_WORDS = 10;
  localparam logic [WORD_BITS-1:0] MARK_WORD = 16'hA5A5;
  localparam logic [WORD_BITS-1:0] POLY_DEF = 16'h1021;
  localparam logic [WORD_BITS-1:0] SEED_DEF = 16'hFFFF;

  typedef enum logic [1:0] {
    PF_IDLE = 2'd0,
    PF_FILL = 2'd1,
    PF_SEND = 2'd2
  } pf_state_t;
endpackage

// File: rtl/pf_crc_acc.sv
module pf_crc_acc #(
  parameter int unsigned WORD_W = 16,
  parameter logic [WORD_W-1:0] POLY = 16'h1021,
  parameter logic [WORD_W-1:0] SEED = 16'hFFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clear,
  input  logic              en,
  input  logic [WORD_W-1:0] data,
  output logic [WORD_W-1:0] crc
);
  logic [WORD_W-1:0] nxt;

  // One whole word per clock, most significant bit shifted in first
  always_comb begin
    logic fb;
    nxt = crc;
    for (int i = WORD_W - 1; i >= 0; i--) begin
      fb  = nxt[WORD_W-1] ^ data[i];
      nxt = {nxt[WORD_W-2:0], 1'b0};
      if (fb) nxt = nxt ^ POLY;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     crc <= SEED;
    else if (clear) crc <= SEED;
    else if (en)    crc <= nxt;
  end
endmodule

// File: rtl/pf_payload_buf.sv
module pf_payload_buf #(
  parameter int unsigned WORD_W = 16,
  parameter int unsigned DEPTH  = 10,
  parameter int unsigned IDX_W  = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [WORD_W-1:0] wr_data,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [WORD_W-1:0] rd_data
);
  logic [WORD_W-1:0] slot [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_slot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                                  slot[g] <= '0;
      else if (wr_en && wr_idx == IDX_W'(g))       slot[g] <= wr_data;
    end
  end

  always_comb begin
    rd_data = '0;
    for (int i = 0; i < DEPTH; i++)
      if (rd_idx == IDX_W'(i)) rd_data = slot[i];
  end

  // R2: a write never lands outside the holding store
  assert_wr_in_range_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> (wr_idx < IDX_W'(DEPTH)));
endmodule

// File: rtl/pf_ctrl.sv
module pf_ctrl
  import pkt_framer_pkg::*;
#(
  parameter int unsigned PAY_WORDS = 10,
  parameter int unsigned IDX_W     = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             in_valid,
  input  logic             out_ready,
  output logic             in_ready,
  output logic             out_valid,
  output logic             out_sop,
  output logic             out_eop,
  output logic             wr_en,
  output logic [IDX_W-1:0] wr_idx,
  output logic             crc_clear,
  output logic             crc_en,
  output logic [IDX_W-1:0] tx_idx
);
  localparam logic [IDX_W-1:0] FILL_LAST = IDX_W'(PAY_WORDS - 1);
  localparam logic [IDX_W-1:0] PKT_LAST  = IDX_W'(PAY_WORDS + 1);

  pf_state_t state;
  logic [IDX_W-1:0] fill_cnt, tx_cnt;
  logic take, emit;

  assign in_ready  = (state == PF_FILL);
  assign out_valid = (state == PF_SEND);
  assign take      = in_valid && in_ready;
  assign emit      = out_valid && out_ready;
  assign out_sop   = out_valid && (tx_cnt == '0);
  assign out_eop   = out_valid && (tx_cnt == PKT_LAST);
  assign wr_en     = take;
  assign wr_idx    = fill_cnt;
  assign crc_en    = take;
  assign crc_clear = (state == PF_IDLE) && start;
  assign tx_idx    = tx_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= PF_IDLE;
      fill_cnt <= '0;
      tx_cnt   <= '0;
    end else begin
      unique case (state)
        PF_IDLE: if (start) begin
          state    <= PF_FILL;
          fill_cnt <= '0;
        end
        PF_FILL: if (take) begin
          if (fill_cnt == FILL_LAST) begin
            state  <= PF_SEND;
            tx_cnt <= '0;
          end else begin
            fill_cnt <= fill_cnt + 1'b1;
          end
        end
        PF_SEND: if (emit) begin
          if (tx_cnt == PKT_LAST) state <= PF_IDLE;
          else                    tx_cnt <= tx_cnt + 1'b1;
        end
        default: state <= PF_IDLE;
      endcase
    end
  end

  // R7: input side closed whenever the output side is busy
  assert_no_overlap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(in_ready && out_valid));
  // R3: the tenth accepted word opens the output with the start marker
  assert_fill_to_send_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (take && fill_cnt == FILL_LAST) |=> (out_valid && out_sop && !in_ready));
  // R5: after the final word leaves, the framer is idle
  assert_eop_ends_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (emit && out_eop) |=> (!out_valid && !in_ready));
endmodule

// File: rtl/pkt_framer.sv
module pkt_framer
  import pkt_framer_pkg::*;
#(
  parameter int unsigned WORD_W    = WORD_BITS,
  parameter int unsigned PAY_WORDS = BODY_WORDS,
  parameter logic [WORD_W-1:0] PREAMBLE = MARK_WORD,
  parameter logic [WORD_W-1:0] CRC_POLY = POLY_DEF,
  parameter logic [WORD_W-1:0] CRC_SEED = SEED_DEF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic              in_valid,
  input  logic [WORD_W-1:0] in_data,
  output logic              in_ready,
  output logic              out_valid,
  output logic [WORD_W-1:0] out_data,
  output logic              out_sop,
  output logic              out_eop,
  input  logic              out_ready
);
  localparam int unsigned PKT_WORDS = PAY_WORDS + 2;
  localparam int unsigned IDX_W     = $clog2(PKT_WORDS);

  logic              wr_en, crc_clear, crc_en;
  logic [IDX_W-1:0]  wr_idx, tx_idx, rd_idx;
  logic [WORD_W-1:0] rd_data, crc_val;

  pf_ctrl #(.PAY_WORDS(PAY_WORDS), .IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .out_ready(out_ready), .in_ready(in_ready), .out_valid(out_valid),
    .out_sop(out_sop), .out_eop(out_eop), .wr_en(wr_en), .wr_idx(wr_idx),
    .crc_clear(crc_clear), .crc_en(crc_en), .tx_idx(tx_idx)
  );

  pf_crc_acc #(.WORD_W(WORD_W), .POLY(CRC_POLY), .SEED(CRC_SEED)) u_crc (
    .clk(clk), .rst_n(rst_n), .clear(crc_clear), .en(crc_en),
    .data(in_data), .crc(crc_val)
  );

  pf_payload_buf #(.WORD_W(WORD_W), .DEPTH(PAY_WORDS), .IDX_W(IDX_W)) u_buf (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(in_data), .rd_idx(rd_idx), .rd_data(rd_data)
  );

  // Payload slots start at packet word index 2
  assign rd_idx = tx_idx - IDX_W'(2);

  always_comb begin
    if (tx_idx == '0)               out_data = PREAMBLE;
    else if (tx_idx == IDX_W'(1))   out_data = crc_val;
    else                            out_data = rd_data;
  end

  // R6: a stalled output word and its markers are held
  assert_hold_stall_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=>
      (out_valid && $stable(out_data) && $stable(out_sop) && $stable(out_eop)));
  // R3: the start marker always rides on the fixed marker word
  assert_sop_word_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sop) |-> (out_data == PREAMBLE && !out_eop));
endmodule

// File: tb/pkt_framer_tb.sv
`timescale 1ns/1ps
module pkt_framer_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic        in_valid = 1'b0;
  logic [15:0] in_data = '0;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_sop, out_eop;
  logic        out_ready = 1'b0;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pkt_framer u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
    .in_data(in_data), .in_ready(in_ready), .out_valid(out_valid),
    .out_data(out_data), .out_sop(out_sop), .out_eop(out_eop),
    .out_ready(out_ready)
  );

  // Stimulus rows: base, step, input gaps, output stalls, poke start
  // Expected packet words are derived from each row by the bench model
  localparam int NVEC = 6;
  localparam logic [34:0] VEC [NVEC] = '{
    {16'h0000, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'hFFFF, 16'h0000, 1'b0, 1'b0, 1'b0},
    {16'h0001, 16'h0001, 1'b0, 1'b0, 1'b0},
    {16'h5555, 16'h1111, 1'b1, 1'b1, 1'b0},
    {16'h8000, 16'h0101, 1'b0, 1'b1, 1'b0},
    {16'h1234, 16'h0F0F, 1'b1, 1'b0, 1'b1}
  };

  function automatic logic [15:0] model_crc(input logic [15:0] w [10]);
    logic [15:0] c = 16'hFFFF;
    for (int k = 0; k < 10; k++)
      for (int b = 15; b >= 0; b--) begin
        if (c[15] ^ w[k][b]) c = (c << 1) ^ 16'h1021;
        else                 c = c << 1;
      end
    return c;
  endfunction

  task automatic check(input bit ok, input string req, input logic [15:0] act,
                       input logic [15:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run_packet(input logic [15:0] base, input logic [15:0] step,
                            input bit gaps, input bit stalls, input bit poke);
    logic [15:0] w [10];
    logic [15:0] exp_w, crc_exp, prev_data;
    bit prev_stall;
    int k, j, cyc;
    for (int i = 0; i < 10; i++) w[i] = base + step * 16'(i);
    crc_exp = model_crc(w);

    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    check(in_ready == 1'b1, "R2 in_ready after start", {15'd0, in_ready}, 16'd1);

    k = 0; cyc = 0;
    while (k < 10) begin
      if (cyc != 0) @(negedge clk);
      cyc++;
      start = (poke && k == 4);
      if (gaps && (cyc % 3 == 0)) in_valid = 1'b0;
      else begin
        in_valid = 1'b1;
        in_data  = w[k];
        if (in_ready) k++;
      end
    end
    @(negedge clk); in_valid = 1'b0; in_data = 16'hDEAD; start = 1'b0;
    check(out_valid == 1'b1 && in_ready == 1'b0, "R3 output opens after tenth word",
          {14'd0, out_valid, in_ready}, 16'h0002);

    j = 0; cyc = 0; prev_stall = 1'b0; prev_data = '0;
    while (j < 12) begin
      if (cyc != 0) @(negedge clk);
      cyc++;
      start = (poke && j == 5);
      if (prev_stall)
        check(out_valid && out_data == prev_data, "R6 word held while stalled",
              out_data, prev_data);
      if (out_valid && in_ready)
        check(1'b0, "R7 in_ready low while sending", {15'd0, in_ready}, 16'd0);
      out_ready = stalls ? (cyc % 3 != 0) : 1'b1;
      prev_stall = out_valid && !out_ready;
      prev_data  = out_data;
      if (out_valid && out_ready) begin
        exp_w = (j == 0) ? 16'hA5A5 : (j == 1) ? crc_exp : w[j-2];
        if (j == 0) check(out_data == exp_w && out_sop && !out_eop, "R3 marker word with sop",
                          out_data, exp_w);
        else if (j == 1) check(out_data == exp_w && !out_sop && !out_eop, "R4 crc word",
                               out_data, exp_w);
        else check(out_data == exp_w && !out_sop && (out_eop == (j == 11)),
                   "R5 payload word and eop", out_data, exp_w);
        j++;
      end
    end
    @(negedge clk); out_ready = 1'b0; start = 1'b0;
    check(!out_valid && !in_ready, "R7 idle after packet (start pokes ignored)",
          {14'd0, out_valid, in_ready}, 16'd0);
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    check(!in_ready && !out_valid && !out_sop && !out_eop, "R1 outputs during reset",
          {12'd0, in_ready, out_valid, out_sop, out_eop}, 16'd0);
    rst_n = 1'b1;
    @(negedge clk);
    check(!in_ready && !out_valid && !out_sop && !out_eop, "R1 outputs after reset",
          {12'd0, in_ready, out_valid, out_sop, out_eop}, 16'd0);

    // Table walk
    for (int v = 0; v < NVEC; v++)
      run_packet(VEC[v][34:19], VEC[v][18:3], VEC[v][2], VEC[v][1], VEC[v][0]);

    // R8: words offered while idle are not taken and never show up later
    for (int i = 0; i < 4; i++) begin
      @(negedge clk); in_valid = 1'b1; in_data = 16'hBEEF;
      check(in_ready == 1'b0, "R8 input closed while idle", {15'd0, in_ready}, 16'd0);
    end
    @(negedge clk); in_valid = 1'b0;
    run_packet(16'h0F00, 16'h0003, 1'b0, 1'b0, 1'b0);

    // R6: long stall on the marker word
    @(negedge clk); start = 1'b1;
    @(negedge clk); start = 1'b0;
    for (int i = 0; i < 10; i++) begin
      in_valid = 1'b1; in_data = 16'(i * 7);
      @(negedge clk);
    end
    in_valid = 1'b0;
    for (int i = 0; i < 5; i++) begin
      check(out_valid && out_sop && out_data == 16'hA5A5, "R6 marker held under stall",
            out_data, 16'hA5A5);
      @(negedge clk);
    end
    out_ready = 1'b1;
    for (int i = 0; i < 12; i++) @(negedge clk);
    out_ready = 1'b0;
    check(!out_valid, "R5 packet drained", {15'd0, out_valid}, 16'd0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule